// File: doc/BRIEF.md
# Resettable 16-bit Timer/Counter

This peripheral holds a 16-bit count that is read and written one byte at a time through a small register port. It steps on one of two sources. The first is an internal count enable. The second is rising edges of an external clock pin, which can pass through a two-flop synchroniser or be taken unsynchronised. Before the count sees an event, the event goes through a selectable 1/2/4/8 prescaler. When the count wraps from all ones to zero, the block sets a sticky overflow flag. It raises an interrupt request while that flag and its enable are both set.

The block has two kinds of reset. `rst_ni` is the power-on/brown-out reset: it clears the control register, which stops the timer and selects a 1:1 ratio. `warm_rst_i` covers every other reset and leaves the control register alone. Both kinds clear the flag and enable bits. Neither kind touches the count. The count is cleared only by a special-event pulse from either of two capture/compare channels.

Register map (byte address on `addr_i`): 0 count low byte, 1 count high byte, 2 control, 3 flag (bit 0), 4 enable (bit 0). Control bits: [0] run, [1] source select (1 = external pin), [2] sync bypass (0 = synchronised), [3] oscillator enable (stored only), [5:4] prescale select.

Top module: `tmr16_unit`

## Requirements
- R1: `rst_ni` low clears the control register to 00h. A `warm_rst_i` pulse leaves it unchanged.
- R2: The count bytes are not altered by `warm_rst_i`.
- R3: Both reset kinds clear the overflow flag and the interrupt enable bit.
- R4: Prescale select 0, 1, 2 and 3 counts one step per 1, 2, 4 and 8 source events.
- R5: A write to either count byte clears the prescaler's internal count.
- R6: A wrap from FFFFh to 0000h sets the flag. The flag stays set until a write of 0 to bit 0 of address 3.
- R7: `irq_o` is high exactly when the flag and the enable (bit 0 of address 4) are both set.
- R8: A pulse on either special-event input clears the count to 0000h on the next edge, even when a count byte is written in the same cycle.
- R9: A count byte write in the same cycle as an increment stores the written byte, and no increment happens.
- R10: With run = 0 the count holds. With source select 0 it counts `tick_i`. With source select 1 it counts rising edges of `ext_clk_i` only, and a held level does not count.
- R11: In synchronised mode, an external edge reaches the count on the third clock edge after it. With sync bypass set, it reaches the count on the second.
- R12: Control bits 7:6 read 0, and the unused bits of the flag and enable registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Power-on/brown-out reset, active low, asynchronous |
| warm_rst_i | input | 1 | Other-reset pulse, synchronous, active high |
| tick_i | input | 1 | Internal count enable |
| ext_clk_i | input | 1 | External clock pin |
| evt_a_i | input | 1 | Special-event clear, channel A |
| evt_b_i | input | 1 | Special-event clear, channel B |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit count, 2-bit prescale select and a two-stage synchroniser. These values make every divide ratio, including the full 1:8 cycle, a short run. They also let the bench reach a wrap from a preloaded FFFEh and measure the synchroniser latency of three edges against two exactly. Preloading keeps the overflow case reachable within a few cycles instead of 65536.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  typedef struct packed {
    logic [1:0] ps;
    logic       osc_en;
    logic       sync_n;
    logic       ext_sel;
    logic       run;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr16_src_sel.sv
module tmr16_src_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ext_clk_i,
  input  logic ext_sel_i,
  input  logic sync_n_i,
  input  logic run_i,
  output logic evt_o
);
  logic [SYNC_STAGES-1:0] sh_q;
  logic prev_q, chosen, edge_hit;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= ext_clk_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[SYNC_STAGES-2:0], ext_clk_i};
    end
  endgenerate

  assign chosen = sync_n_i ? sh_q[0] : sh_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chosen;

  assign edge_hit = chosen & ~prev_q;
  assign evt_o    = run_i & (ext_sel_i ? edge_hit : tick_i);
endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int PS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            inc_i,
  input  logic [PS_W-1:0] sel_i,
  output logic            fire_o
);
  localparam int PC_W = (1 << PS_W) - 1;
  logic [PC_W-1:0] pc_q, mask;

  assign mask   = PC_W'((1 << sel_i) - 1);
  assign fire_o = inc_i & ((pc_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     pc_q <= '0;
    else if (clr_i)  pc_q <= '0;
    else if (fire_o) pc_q <= '0;
    else if (inc_i)  pc_q <= pc_q + 1'b1;
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int CNT_W = 16,
  localparam int NB   = CNT_W / 8
) (
  input  logic             clk_i,
  input  logic             clr_i,
  input  logic [NB-1:0]    wr_byte_i,
  input  logic [7:0]       wdata_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    wrap_o = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (|wr_byte_i) begin
      for (int b = 0; b < NB; b++)
        if (wr_byte_i[b]) cnt_d[b*8 +: 8] = wdata_i;
    end else if (inc_i) begin
      cnt_d  = cnt_q + 1'b1;
      wrap_o = &cnt_q;
    end
  end

  // count survives every reset by design
  always_ff @(posedge clk_i) cnt_q <= cnt_d;

  assign count_o = cnt_q;
endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit #(
  parameter int CNT_W       = 16,
  parameter int PS_W        = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3,
  localparam int NB         = CNT_W / 8,
  localparam int A_CTRL     = NB,
  localparam int A_FLAG     = NB + 1,
  localparam int A_IE       = NB + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              warm_rst_i,
  input  logic              tick_i,
  input  logic              ext_clk_i,
  input  logic              evt_a_i,
  input  logic              evt_b_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  import tmr16_pkg::*;

  tmr_ctrl_t        ctrl_q;
  logic             flag_q, ie_q;
  logic [NB-1:0]    wr_byte;
  logic             cnt_wr, ctrl_wr, flag_wr, ie_wr, evt_clr;
  logic             src_evt, ps_fire, wrap;
  logic [CNT_W-1:0] count_q;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_wr
      assign wr_byte[b] = wr_i && (addr_i == ADDR_W'(b));
    end
  endgenerate

  assign cnt_wr  = |wr_byte;
  assign ctrl_wr = wr_i && (addr_i == ADDR_W'(A_CTRL));
  assign flag_wr = wr_i && (addr_i == ADDR_W'(A_FLAG));
  assign ie_wr   = wr_i && (addr_i == ADDR_W'(A_IE));
  assign evt_clr = evt_a_i | evt_b_i;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= tmr_ctrl_t'(wdata_i[5:0]);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         flag_q <= 1'b0;
    else if (warm_rst_i) flag_q <= 1'b0;
    else if (wrap)       flag_q <= 1'b1;
    else if (flag_wr)    flag_q <= wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)         ie_q <= 1'b0;
    else if (warm_rst_i) ie_q <= 1'b0;
    else if (ie_wr)      ie_q <= wdata_i[0];

  tmr16_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i, .rst_ni, .tick_i, .ext_clk_i,
    .ext_sel_i(ctrl_q.ext_sel), .sync_n_i(ctrl_q.sync_n),
    .run_i(ctrl_q.run), .evt_o(src_evt)
  );

  tmr16_prescale #(.PS_W(PS_W)) u_ps (
    .clk_i, .rst_ni, .clr_i(cnt_wr), .inc_i(src_evt),
    .sel_i(ctrl_q.ps), .fire_o(ps_fire)
  );

  tmr16_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .clr_i(evt_clr), .wr_byte_i(wr_byte), .wdata_i,
    .inc_i(ps_fire), .count_o(count_q), .wrap_o(wrap)
  );

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NB; b++)
      if (addr_i == ADDR_W'(b)) rdata_o = count_q[b*8 +: 8];
    if (addr_i == ADDR_W'(A_CTRL)) rdata_o = {2'b00, ctrl_q};
    if (addr_i == ADDR_W'(A_FLAG)) rdata_o = {7'b0, flag_q};
    if (addr_i == ADDR_W'(A_IE))   rdata_o = {7'b0, ie_q};
  end

  assign irq_o = flag_q & ie_q;
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3,
  parameter int A_CTRL = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              warm_rst_i,
  input logic              evt_clr,
  input logic              cnt_wr,
  input logic              ctrl_wr,
  input logic              flag_wr,
  input logic              run,
  input logic [CNT_W-1:0]  count_q,
  input logic [5:0]        ctrl_bits,
  input logic              flag_q,
  input logic              ie_q,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        rdata_o
);
  AST_EVT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_clr |=> count_q == '0); // R8
  AST_CTRL_KEPT_WARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_i && !ctrl_wr |=> $stable(ctrl_bits)); // R1
  AST_WARM_CLEARS_IRQ_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_i |=> !flag_q && !ie_q); // R3
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !warm_rst_i && !flag_wr |=> flag_q); // R6
  AST_OFF_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run && !evt_clr && !cnt_wr |=> $stable(count_q)); // R10
  AST_CTRL_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(A_CTRL) |-> rdata_o[7:6] == 2'b00); // R12
endmodule

bind tmr16_unit tmr16_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .A_CTRL(A_CTRL)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .warm_rst_i(warm_rst_i), .evt_clr(evt_clr),
  .cnt_wr(cnt_wr), .ctrl_wr(ctrl_wr), .flag_wr(flag_wr), .run(ctrl_q.run),
  .count_q(count_q), .ctrl_bits(ctrl_q), .flag_q(flag_q), .ie_q(ie_q),
  .addr_i(addr_i), .rdata_o(rdata_o)
);

// File: tb/tmr16_unit_tb_top.sv
module tmr16_unit_tb_top;
  logic clk_i = 0, rst_ni = 0, warm_rst_i = 0, tick_i = 0, ext_clk_i = 0;
  logic evt_a_i = 0, evt_b_i = 0, wr_i = 0, irq_o;
  logic [2:0] addr_i = 0;
  logic [7:0] wdata_i = 0, rdata_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  tmr16_unit dut_i (.*);

  typedef struct packed {logic [1:0] ps; logic [7:0] n; logic [15:0] exp;} vec_t;
  localparam vec_t VECS [6] = '{
    '{2'd0, 8'd10, 16'd10}, '{2'd1, 8'd10, 16'd5}, '{2'd2, 8'd10, 16'd2},
    '{2'd3, 8'd20, 16'd2},  '{2'd3, 8'd7,  16'd0}, '{2'd2, 8'd16, 16'd4}};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1;
    @(negedge clk_i); wr_i = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(0, lo); rd(1, hi); v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    tick_i = 1; repeat (n) @(negedge clk_i); tick_i = 0;
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v, c0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    rd(2, b); check("R1 ctrl after power-on reset", b, 0);
    rd(3, b); check("R3 flag after reset", b, 0);
    rd(4, b); check("R3 enable after reset", b, 0);
    check("R7 irq after reset", irq_o, 0);

    // R4 / R5 ratio table
    foreach (VECS[i]) begin
      wr(2, 0); wr(0, 0); wr(1, 0);
      wr(2, {2'b00, VECS[i].ps, 4'b0001});
      ticks(VECS[i].n);
      wr(2, 0);
      rd16(v); check("R4 prescale ratio", v, VECS[i].exp);
    end

    // R10 timer off holds
    wr(0, 8'h44); wr(1, 0); ticks(5);
    rd16(v); check("R10 run=0 holds count", v, 16'h0044);

    // R12 reserved bits
    wr(2, 8'hFF); rd(2, b); check("R12 ctrl top bits read 0", b, 8'h3F);
    wr(3, 8'hFE); rd(3, b); check("R12 flag unused bits", b, 0);
    wr(2, 0);

    // R5 write clears prescaler
    wr(2, 8'h31); ticks(5);
    wr(0, 8'h10); wr(1, 0);
    ticks(7); rd16(v); check("R5 prescaler cleared by write", v, 16'h0010);
    ticks(1); rd16(v); check("R5 step after full 8", v, 16'h0011);

    // R6 / R7 overflow
    wr(2, 0); wr(0, 8'hFE); wr(1, 8'hFF); wr(2, 8'h01);
    ticks(2);
    rd16(v); check("R6 wrap to zero", v, 16'h0000);
    rd(3, b); check("R6 flag set on wrap", b, 1);
    check("R7 irq masked", irq_o, 0);
    wr(4, 1); check("R7 irq when enabled", irq_o, 1);
    wr(2, 0); repeat (3) @(negedge clk_i);
    rd(3, b); check("R6 flag sticky", b, 1);
    wr(3, 0); rd(3, b); check("R6 flag cleared by write", b, 0);
    check("R7 irq drops", irq_o, 0);

    // R1 / R2 / R3 warm reset
    wr(4, 1); wr(3, 1); wr(2, 8'h31); wr(0, 8'h34); wr(1, 8'h12);
    @(negedge clk_i); warm_rst_i = 1; @(negedge clk_i); warm_rst_i = 0;
    rd(2, b); check("R1 ctrl kept by warm reset", b, 8'h31);
    rd16(v); check("R2 count kept by warm reset", v, 16'h1234);
    rd(3, b); check("R3 flag cleared by warm reset", b, 0);
    rd(4, b); check("R3 enable cleared by warm reset", b, 0);

    // R9 write beats increment
    wr(2, 8'h01); wr(1, 0);
    @(negedge clk_i); addr_i = 0; wdata_i = 8'h55; wr_i = 1; tick_i = 1;
    @(negedge clk_i); wr_i = 0; tick_i = 0;
    rd16(v); check("R9 write wins over increment", v, 16'h0055);

    // R8 special event
    @(negedge clk_i); evt_a_i = 1; addr_i = 0; wdata_i = 8'h77; wr_i = 1;
    @(negedge clk_i); evt_a_i = 0; wr_i = 0;
    rd16(v); check("R8 event beats write", v, 0);
    wr(0, 8'h21); wr(1, 8'h43);
    @(negedge clk_i); evt_b_i = 1; @(negedge clk_i); evt_b_i = 0;
    rd16(v); check("R8 channel B clears", v, 0);

    // R10 / R11 external, synchronised
    wr(2, 8'h03); tick_i = 1; repeat (4) @(negedge clk_i); tick_i = 0;
    rd16(c0); check("R10 tick ignored in external mode", c0, 0);
    ext_clk_i = 1;
    @(negedge clk_i); rd16(v); check("R11 sync 1 edge", v, c0);
    @(negedge clk_i); rd16(v); check("R11 sync 2 edges", v, c0);
    @(negedge clk_i); rd16(v); check("R11 sync 3 edges", v, c0 + 1);
    repeat (4) @(negedge clk_i); rd16(v); check("R10 level not counted", v, c0 + 1);
    ext_clk_i = 0;

    // R11 bypass
    wr(2, 8'h07); repeat (4) @(negedge clk_i);
    rd16(c0); ext_clk_i = 1;
    @(negedge clk_i); rd16(v); check("R11 bypass 1 edge", v, c0);
    @(negedge clk_i); rd16(v); check("R11 bypass 2 edges", v, c0 + 1);
    ext_clk_i = 0;

    // R1 power-on reset again
    wr(2, 8'h35);
    @(negedge clk_i); rst_ni = 0; @(negedge clk_i); rst_ni = 1;
    rd(2, b); check("R1 ctrl cleared by power-on reset", b, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule